// File: doc/BRIEF.md
# Phase-Error Lock Monitor

This block watches a reference edge stream and a feedback edge stream, both already reduced to one-cycle pulses in a fast measurement clock domain. It pairs each reference edge with the matching feedback edge, counts the ticks between them, and reports that distance once per phase-detector cycle. The edge that arrives first opens the window, and the other edge closes it.

A loss-of-lock flag is built from these measurements with hysteresis. A large error sets the flag. Only a small error clears it again. An error between the two thresholds leaves the flag as it was. Every measurement is judged on its own, so the flag can change from one cycle to the next while a loop settles.

A partner edge that never comes, or a measurement clock with no edges at all, is reported after a programmable number of ticks as a saturated error. Each completed measurement also emits a one-cycle pulse that tells whether the error fell inside the tight window. A relock counter elsewhere can count these pulses.

Top module: `phase_lock_monitor`

## Requirements
- R1: While reset is applied, and in the cycles just after it, `lol` is 1, `meas_valid` is 0 and `tight_pulse` is 0.
- R2: `err_mag` reports the tick distance between paired edges, whichever edge came first. An edge sampled on the same tick as its partner gives 0. `meas_valid` pulses for one cycle on the cycle after the later edge is sampled.
- R3: A measurement whose `err_mag` is strictly greater than `thr_assert_ticks` drives `lol` to 1. An error equal to the threshold does not.
- R4: `lol` falls to 0 only on a measurement whose `err_mag` is strictly below `thr_release_ticks`. An error at or between the two thresholds leaves `lol` unchanged.
- R5: `tight_pulse` is 1, in the same cycle as `meas_valid`, exactly when that measurement's error is strictly below `thr_release_ticks`.
- R6: The first edge opens a window. If no partner edge is sampled by the tick where the count equals `timeout_ticks`, a measurement is reported with `err_mag` all ones, `tight_pulse` 0 and `lol` 1. A partner edge sampled on that same tick still completes a normal measurement, with `err_mag` equal to `timeout_ticks`.
- R7: If no edge of either kind arrives for `timeout_ticks`+1 cycles after the last measurement, a timeout measurement is reported, as in R6.
- R8: After reset, `lol` stays 1 through any measurement that is not below the release threshold, until the first one that is.
- R9: Consecutive measurements are judged independently, so `lol` can go 1, 0, 1, 0 on back-to-back measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_meas | input | 1 | Fast measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_edge | input | 1 | One-cycle pulse per sampled reference rising edge |
| fb_edge | input | 1 | One-cycle pulse per sampled feedback rising edge |
| thr_assert_ticks | input | CNT_W | Error above this sets loss of lock |
| thr_release_ticks | input | CNT_W | Error below this clears loss of lock |
| timeout_ticks | input | CNT_W | Ticks to wait for an edge before reporting a timeout |
| lol | output | 1 | 1 = loss of lock, 0 = locked |
| tight_pulse | output | 1 | Per-measurement pulse: error below release threshold |
| meas_valid | output | 1 | Per-measurement pulse: `err_mag` updated |
| err_mag | output | CNT_W | Magnitude of the last measured error in ticks |

## Verification
Two outcomes can fall on the same tick: a partner edge completing a measurement, and the timeout for that window expiring. The bench provokes this by sending the partner exactly `timeout_ticks` ticks after the opening edge. It expects a normal measurement equal to the timeout, not a saturated one. The other collision, a reference and a feedback edge on the same tick, is judged by expecting a zero error and a tight pulse rather than the opening of a window.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [1:0] {
    PAIR_IDLE     = 2'd0,
    PAIR_WAIT_FB  = 2'd1,
    PAIR_WAIT_REF = 2'd2
  } pair_state_e;
endpackage

// File: rtl/plm_edge_pair.sv
module plm_edge_pair
  import plm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             fb_edge,
  input  logic [CNT_W-1:0] timeout_ticks,
  output logic             done,
  output logic             tmo,
  output logic [CNT_W-1:0] mag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pair_state_e      state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             expired;

  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + ONE;
  assign expired = (cnt_q >= timeout_ticks);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_inc;
    done    = 1'b0;
    tmo     = 1'b0;
    mag     = '0;
    unique case (state_q)
      PAIR_IDLE: begin
        if (ref_edge && fb_edge) begin
          done  = 1'b1;
          cnt_n = '0;
        end else if (ref_edge) begin
          state_n = PAIR_WAIT_FB;
          cnt_n   = ONE;
        end else if (fb_edge) begin
          state_n = PAIR_WAIT_REF;
          cnt_n   = ONE;
        end else if (expired) begin
          tmo   = 1'b1;
          cnt_n = '0;
        end
      end
      PAIR_WAIT_FB, PAIR_WAIT_REF: begin
        if ((state_q == PAIR_WAIT_FB) ? fb_edge : ref_edge) begin
          done    = 1'b1;
          mag     = cnt_q;
          state_n = PAIR_IDLE;
          cnt_n   = '0;
        end else if (expired) begin
          tmo     = 1'b1;
          state_n = PAIR_IDLE;
          cnt_n   = '0;
        end
      end
      default: begin
        state_n = PAIR_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PAIR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/plm_hyst_flag.sv
module plm_hyst_flag #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             tmo,
  input  logic [CNT_W-1:0] mag,
  input  logic [CNT_W-1:0] thr_assert,
  input  logic [CNT_W-1:0] thr_release,
  output logic             lol,
  output logic             tight,
  output logic             valid,
  output logic [CNT_W-1:0] err_mag
);
  logic             lol_q, lol_n, tight_q, tight_n, valid_q, valid_n;
  logic [CNT_W-1:0] mag_q, mag_n;
  logic             upd, is_big, is_small;

  assign upd      = done | tmo;
  assign is_big   = tmo | (done & (mag > thr_assert));
  assign is_small = done & (mag < thr_release);

  always_comb begin
    valid_n = upd;
    tight_n = is_small;
    mag_n   = mag_q;
    lol_n   = lol_q;
    if (upd) mag_n = tmo ? '1 : mag;
    if (is_big)        lol_n = 1'b1;
    else if (is_small) lol_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lol_q   <= 1'b1;
      tight_q <= 1'b0;
      valid_q <= 1'b0;
      mag_q   <= '0;
    end else begin
      lol_q   <= lol_n;
      tight_q <= tight_n;
      valid_q <= valid_n;
      if (upd) mag_q <= mag_n;
    end
  end

  assign lol     = lol_q;
  assign tight   = tight_q;
  assign valid   = valid_q;
  assign err_mag = mag_q;

  // R3
  big_err_sets_lol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && (mag_q > $past(thr_assert))) |-> lol_q);
  // R4
  release_needs_tight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol_q) |-> (valid_q && tight_q));
  // R5
  tight_is_locked_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tight_q |-> (valid_q && !lol_q));
  // R6
  lol_rise_on_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lol_q) |-> valid_q);
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int CNT_W      = 8,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_meas,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             fb_edge,
  input  logic [CNT_W-1:0] thr_assert_ticks,
  input  logic [CNT_W-1:0] thr_release_ticks,
  input  logic [CNT_W-1:0] timeout_ticks,
  output logic             lol,
  output logic             tight_pulse,
  output logic             meas_valid,
  output logic [CNT_W-1:0] err_mag
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_s;
  logic                  pr_done, pr_tmo;
  logic [CNT_W-1:0]      pr_mag;

  always_ff @(posedge clk_meas or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s = rst_pipe[RST_STAGES-1];

  plm_edge_pair #(.CNT_W(CNT_W)) pair_i (
    .clk           (clk_meas),
    .rst_n         (rst_s),
    .ref_edge      (ref_edge),
    .fb_edge       (fb_edge),
    .timeout_ticks (timeout_ticks),
    .done          (pr_done),
    .tmo           (pr_tmo),
    .mag           (pr_mag)
  );

  plm_hyst_flag #(.CNT_W(CNT_W)) flag_i (
    .clk         (clk_meas),
    .rst_n       (rst_s),
    .done        (pr_done),
    .tmo         (pr_tmo),
    .mag         (pr_mag),
    .thr_assert  (thr_assert_ticks),
    .thr_release (thr_release_ticks),
    .lol         (lol),
    .tight       (tight_pulse),
    .valid       (meas_valid),
    .err_mag     (err_mag)
  );
endmodule

// File: tb/phase_lock_monitor_tb_top.sv
module phase_lock_monitor_tb_top;
  localparam int W = 8;
  localparam int TMO = 40;
  localparam int THA = 8;
  localparam int THR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0, fb_edge = 1'b0;
  logic lol, tight_pulse, meas_valid;
  logic [W-1:0] err_mag;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  bit model_lol = 1'b1;

  typedef struct {
    logic [W-1:0] mag;
    bit           tight;
    bit           lol;
    string        req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  phase_lock_monitor #(.CNT_W(W)) dut_i (
    .clk_meas(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .thr_assert_ticks(8'(THA)), .thr_release_ticks(8'(THR)),
    .timeout_ticks(8'(TMO)), .lol(lol), .tight_pulse(tight_pulse),
    .meas_valid(meas_valid), .err_mag(err_mag));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: push expectation, then produce the edge pair.
  task automatic push_meas(input int gap, input string req);
    exp_t e;
    e.mag = 8'(gap);
    e.tight = (gap < THR);
    if (gap > THA) model_lol = 1'b1;
    else if (gap < THR) model_lol = 1'b0;
    e.lol = model_lol;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_tmo(input string req);
    exp_t e;
    e.mag = 8'hFF; e.tight = 1'b0; model_lol = 1'b1; e.lol = 1'b1; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic measure(input int gap, input bit ref_first, input string req);
    push_meas(gap, req);
    @(negedge clk);
    if (gap == 0) begin
      ref_edge = 1'b1; fb_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0;
    end else begin
      if (ref_first) ref_edge = 1'b1; else fb_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0;
      repeat (gap - 1) @(negedge clk);
      if (ref_first) fb_edge = 1'b1; else ref_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pop and compare on every reported measurement.
  always @(negedge clk) begin
    if (rst_n && meas_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected meas_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(err_mag == e.mag, e.req, "err_mag", int'(err_mag), int'(e.mag));
        check(tight_pulse == e.tight, e.req, "tight_pulse (R5)", int'(tight_pulse), int'(e.tight));
        check(lol == e.lol, e.req, "lol", int'(lol), int'(e.lol));
      end
    end else if (rst_n) begin
      check(tight_pulse == 1'b0, "R5", "tight without meas", int'(tight_pulse), 0);
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(lol == 1'b1 && meas_valid == 1'b0 && tight_pulse == 1'b0, "R1",
          "state in reset", int'({lol, meas_valid, tight_pulse}), 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(lol == 1'b1 && meas_valid == 1'b0, "R1", "state after reset",
          int'({lol, meas_valid}), 2);
    measure(6, 1'b1, "R8");
    measure(2, 1'b0, "R2");
    measure(0, 1'b1, "R2");
    measure(6, 1'b1, "R4");
    measure(8, 1'b0, "R3");
    measure(9, 1'b1, "R3");
    measure(4, 1'b1, "R4");
    measure(3, 1'b0, "R4");
    measure(12, 1'b0, "R9");
    measure(1, 1'b1, "R9");
    measure(11, 1'b1, "R9");
    measure(0, 1'b0, "R9");
    // R6: partner never arrives
    push_tmo("R6");
    @(negedge clk); ref_edge = 1'b1;
    @(negedge clk); ref_edge = 1'b0;
    repeat (TMO + 2) @(negedge clk);
    measure(3, 1'b1, "R6");
    // R7: no edges at all
    push_tmo("R7");
    repeat (TMO + 10) @(negedge clk);
    // R6: partner on the very tick the timeout would fire
    measure(TMO, 1'b0, "R6");
    measure(2, 1'b1, "R4");
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2", "outstanding expectations", exp_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule